// File: doc/BRIEF.md
# Channel Address Interleave Remover

This block turns a system address into the address seen inside one memory channel. A controller and a channel have already been chosen for the address. The block searches a small table of address ranges held for that controller and picks the first range that contains the address. It subtracts the per-channel offset stored for that range. It then strips out the socket interleave and the channel interleave that the range describes. Each stripping step keeps the address bits below an interleave bit. It divides the bits above that interleave bit by the number of ways and puts them back in place.

Software fills the range table through a simple write port. A lookup starts with a one-cycle `start` strobe. The block answers with a one-cycle `done` pulse. With the pulse it gives either the channel address together with the socket and channel way counts, or a no-entry flag when no range contains the address. When the way count is a power of two, the division is a shift. A three-way channel interleave uses an iterative divide-by-three, so those lookups take longer.

Top module: `chan_ilv_remover`

## Requirements
- R1: After reset, `done` and `no_entry` are low, and `chan_addr`, `skt_ways` and `chn_ways` are all zero.
- R2: Entry i matches when {base[31:12], 26 zero bits} <= address <= {limit[31:12], 26 one bits}. Base is the base word of entry i and limit is its wayness word. Both ends of the range are included.
- R3: Entries are searched from index 0 upward, and the lowest-numbered matching entry wins.
- R4: When no entry matches, `done` pulses together with `no_entry` high, 2 cycles after `start` is sampled.
- R5: On a successful lookup `skt_ways` = 1 << wayness[11:10] and `chn_ways` = wayness[9:8] + 1.
- R6: The running channel address begins as the system address minus {offset[23:4], 26 zero bits}. The offset word used is the one stored for the matched entry and for the channel given on `chan_sel`. The subtraction wraps modulo 2^46.
- R7: The socket interleave bit comes from base[5:4] and the channel interleave bit from base[7:6]. Codes 0, 1, 2 and 3 select bits 6, 8, 12 and 30.
- R8: Removing an interleave at bit s with w ways gives ((x >> s) / w) << s, ORed with bits s-1:0 of a low-bits source. By default the socket interleave is removed first and the channel interleave second, and both steps take their low bits from the original system address.
- R9: When there are 3 channel ways and the socket bit is strictly above the channel bit, the channel interleave is removed first. Both steps then take their low bits from the running value. Equal bits keep the default order.
- R10: `done` is a one-cycle pulse. On a successful lookup it rises 2 + c0 + c1 cycles after `start` is sampled. c0 is the cost of the first removal step and c1 the cost of the second. A step costs 1 cycle when its way count is a power of two and 48 cycles when it is 3.
- R11: A `start` that arrives while a lookup is in flight is ignored, and the running lookup finishes with its own result.
- R12: A write with `cfg_we` high stores `cfg_wdata` into entry `cfg_ent`. `cfg_kind` chooses the word: 0 = base, 1 = wayness, 2 = offset for channel `cfg_ch`. Kind 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_kind | input | 2 | Word selector: 0 base, 1 wayness, 2 offset, 3 none |
| cfg_ent | input | 3 | Entry index for the write |
| cfg_ch | input | 2 | Channel index for offset writes |
| cfg_wdata | input | 32 | Write data |
| start | input | 1 | Lookup strobe, one cycle |
| sys_addr | input | 46 | System address, sampled with `start` |
| chan_sel | input | 2 | Channel chosen earlier, sampled with `start` |
| done | output | 1 | One-cycle completion pulse |
| no_entry | output | 1 | No range matched; valid with `done` |
| chan_addr | output | 46 | Channel address; valid with `done` when `no_entry` is low |
| skt_ways | output | 4 | Socket way count |
| chn_ways | output | 3 | Channel way count |

## Verification
The bench targets these corner cases:
- Addresses exactly at an entry's base and exactly at its limit. A comparison that is off by one sends these to the wrong entry or to no entry.
- Two overlapping ranges. A reversed search order picks the higher-numbered entry and returns the wrong way counts.
- The three-way cases in both removal orders, plus a case with equal socket and channel bits. A design that swaps the order, uses the wrong low-bits source, or uses `>=` in place of `>` returns a different channel address.
- Completion on the exact predicted cycle, and a second `start` during a long divide. A wrong divide length moves `done`, and a lookup that restarts on the second strobe returns the intruder's address.

// File: rtl/chan_ilv_pkg.sv
package chan_ilv_pkg;

    localparam int FLD_W   = 20;
    localparam int UNIT_SH = 26;
    localparam int ADDR_W  = FLD_W + UNIT_SH;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_STEP  = 2'd2,
        ST_WAIT  = 2'd3
    } lookup_st_e;

    // Interleave bit position selected by a 2-bit granularity code.
    function automatic logic [4:0] gran_bit(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd6;
            2'd1:    return 5'd8;
            2'd2:    return 5'd12;
            default: return 5'd30;
        endcase
    endfunction

endpackage

// File: rtl/chan_ilv_regs.sv
module chan_ilv_regs
    import chan_ilv_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int NUM_CH  = 3,
    parameter int ENT_W   = 3,
    parameter int CH_W    = 2
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      we,
    input  logic [1:0]                                kind,
    input  logic [ENT_W-1:0]                          ent,
    input  logic [CH_W-1:0]                           ch,
    input  logic [31:0]                               wdata,
    output logic [NUM_ENT-1:0][FLD_W+3:0]             base_o,
    output logic [NUM_ENT-1:0][FLD_W+3:0]             way_o,
    output logic [NUM_CH-1:0][NUM_ENT-1:0][FLD_W-1:0] off_o
);

    // base word kept as {field, chan code, socket code}
    // wayness word kept as {limit field, socket ways code, chan ways code}
    logic [NUM_ENT-1:0][FLD_W+3:0]             base_d, base_q;
    logic [NUM_ENT-1:0][FLD_W+3:0]             way_d,  way_q;
    logic [NUM_CH-1:0][NUM_ENT-1:0][FLD_W-1:0] off_d,  off_q;

    always_comb begin
        base_d = base_q;
        way_d  = way_q;
        off_d  = off_q;
        if (we && (32'(ent) < NUM_ENT)) begin
            case (kind)
                2'd0: base_d[ent] = {wdata[31:12], wdata[7:4]};
                2'd1: way_d[ent]  = wdata[31:8];
                2'd2: if (32'(ch) < NUM_CH) off_d[ch][ent] = wdata[23:4];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            way_q  <= '0;
            off_q  <= '0;
        end else begin
            base_q <= base_d;
            way_q  <= way_d;
            off_q  <= off_d;
        end
    end

    assign base_o = base_q;
    assign way_o  = way_q;
    assign off_o  = off_q;

endmodule

// File: rtl/chan_ilv_match.sv
module chan_ilv_match
    import chan_ilv_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int ENT_W   = 3
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_ENT-1:0][FLD_W-1:0] lo_fld,
    input  logic [NUM_ENT-1:0][FLD_W-1:0] hi_fld,
    output logic                          hit,
    output logic [ENT_W-1:0]              idx
);

    logic [NUM_ENT-1:0] in_range;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign in_range[g] = ({lo_fld[g], {UNIT_SH{1'b0}}} <= addr) &&
                             (addr <= {hi_fld[g], {UNIT_SH{1'b1}}});
    end

    // lowest index has priority: scan downward so it is written last
    always_comb begin
        idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (in_range[i]) idx = ENT_W'(i);
        end
    end

    assign hit = |in_range;

endmodule

// File: rtl/chan_ilv_div3.sv
module chan_ilv_div3 #(
    parameter int W = 46
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot
);

    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       rem;
        logic [W-1:0]     num;
        logic [W-1:0]     quo;
    } div_state_t;

    div_state_t q, d;
    logic [2:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.num[W-1]};
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(W);
            d.rem  = 2'd0;
            d.num  = dividend;
            d.quo  = '0;
        end else if (q.busy) begin
            d.num = q.num << 1;
            if (trial >= 3'd3) begin
                d.rem = 2'(trial - 3'd3);
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = trial[1:0];
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.done;
    assign quot = q.quo;

    // R10: divider launched only when idle, so step latency is fixed
    p_launch_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

    // R10: remainder of a divide by three never reaches three
    p_rem_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.rem != 2'd3));

endmodule

// File: rtl/chan_ilv_remover.sv
module chan_ilv_remover
    import chan_ilv_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int NUM_CH  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_kind,
    input  logic [$clog2(NUM_ENT)-1:0]   cfg_ent,
    input  logic [$clog2(NUM_CH)-1:0]    cfg_ch,
    input  logic [31:0]                  cfg_wdata,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            sys_addr,
    input  logic [$clog2(NUM_CH)-1:0]    chan_sel,
    output logic                         done,
    output logic                         no_entry,
    output logic [ADDR_W-1:0]            chan_addr,
    output logic [3:0]                   skt_ways,
    output logic [2:0]                   chn_ways
);

    localparam int ENT_W = $clog2(NUM_ENT);
    localparam int CH_W  = $clog2(NUM_CH);

    typedef struct packed {
        lookup_st_e       st;
        logic             step;
        logic [ADDR_W-1:0] orig;
        logic [CH_W-1:0]  ch;
        logic [ADDR_W-1:0] cur;
        logic [1:0]       sgc;
        logic [1:0]       cgc;
        logic [1:0]       swc;
        logic [1:0]       cwc;
        logic             chfirst;
        logic             done;
        logic             noent;
        logic [ADDR_W-1:0] res;
        logic [3:0]       skw;
        logic [2:0]       chw;
    } look_state_t;

    look_state_t q, d;

    logic [NUM_ENT-1:0][FLD_W+3:0]             base_arr, way_arr;
    logic [NUM_CH-1:0][NUM_ENT-1:0][FLD_W-1:0] off_arr;
    logic [NUM_ENT-1:0][FLD_W-1:0]             lo_fld, hi_fld;
    logic                                      m_hit;
    logic [ENT_W-1:0]                          m_idx;

    chan_ilv_regs #(
        .NUM_ENT(NUM_ENT), .NUM_CH(NUM_CH), .ENT_W(ENT_W), .CH_W(CH_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .kind(cfg_kind),
        .ent(cfg_ent), .ch(cfg_ch), .wdata(cfg_wdata),
        .base_o(base_arr), .way_o(way_arr), .off_o(off_arr)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_fld
        assign lo_fld[g] = base_arr[g][FLD_W+3:4];
        assign hi_fld[g] = way_arr[g][FLD_W+3:4];
    end

    chan_ilv_match #(.NUM_ENT(NUM_ENT), .ENT_W(ENT_W)) match_i (
        .addr(q.orig), .lo_fld(lo_fld), .hi_fld(hi_fld),
        .hit(m_hit), .idx(m_idx)
    );

    // per-step interleave parameters
    logic              is_chan, ways3, div_start, div_busy, div_done, adv;
    logic [1:0]        lg;
    logic [4:0]        sh;
    logic [ADDR_W-1:0] low_src, low_mask, hi_part, pow_res, div_res, nxt;
    logic [ADDR_W-1:0] div_quot;
    logic [FLD_W-1:0]  off_sel;
    logic [FLD_W+3:0]  base_sel, way_sel;

    always_comb begin
        is_chan  = q.chfirst ? !q.step : q.step;
        sh       = gran_bit(is_chan ? q.cgc : q.sgc);
        ways3    = is_chan && (q.cwc == 2'd2);
        if (is_chan) lg = (q.cwc == 2'd3) ? 2'd2 : ((q.cwc == 2'd1) ? 2'd1 : 2'd0);
        else         lg = q.swc;
        low_src  = q.chfirst ? q.cur : q.orig;
        low_mask = ~({ADDR_W{1'b1}} << sh);
        hi_part  = q.cur >> sh;
        pow_res  = ((hi_part >> lg) << sh) | (low_src & low_mask);
        div_res  = (div_quot << sh) | (low_src & low_mask);
        base_sel = base_arr[m_idx];
        way_sel  = way_arr[m_idx];
        off_sel  = (32'(q.ch) < NUM_CH) ? off_arr[q.ch][m_idx] : '0;
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        div_start = 1'b0;
        adv       = 1'b0;
        nxt       = pow_res;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.orig = sys_addr;
                    d.ch   = chan_sel;
                    d.st   = ST_MATCH;
                end
            end
            ST_MATCH: begin
                if (!m_hit) begin
                    d.done  = 1'b1;
                    d.noent = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    d.cgc     = base_sel[3:2];
                    d.sgc     = base_sel[1:0];
                    d.swc     = way_sel[3:2];
                    d.cwc     = way_sel[1:0];
                    d.cur     = q.orig - {off_sel, {UNIT_SH{1'b0}}};
                    d.chfirst = (way_sel[1:0] == 2'd2) &&
                                (gran_bit(base_sel[1:0]) > gran_bit(base_sel[3:2]));
                    d.step    = 1'b0;
                    d.st      = ST_STEP;
                end
            end
            ST_STEP: begin
                if (ways3) begin
                    div_start = 1'b1;
                    d.st      = ST_WAIT;
                end else begin
                    adv = 1'b1;
                end
            end
            default: begin
                if (div_done) begin
                    nxt = div_res;
                    adv = 1'b1;
                end
            end
        endcase
        if (adv) begin
            d.cur = nxt;
            if (q.step) begin
                d.st    = ST_IDLE;
                d.done  = 1'b1;
                d.noent = 1'b0;
                d.res   = nxt;
                d.skw   = 4'd1 << q.swc;
                d.chw   = 3'(q.cwc) + 3'd1;
            end else begin
                d.step = 1'b1;
                d.st   = ST_STEP;
            end
        end
    end

    chan_ilv_div3 #(.W(ADDR_W)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(hi_part),
        .busy(div_busy), .done(div_done), .quot(div_quot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done      = q.done;
    assign no_entry  = q.noent;
    assign chan_addr = q.res;
    assign skt_ways  = q.skw;
    assign chn_ways  = q.chw;

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the no-entry flag only rises together with completion
    p_noent_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_entry) |-> done);

    // R5: reported way counts are legal encodings
    p_ways_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_entry) |-> ($onehot(skt_ways) && chn_ways != 3'd0 && chn_ways <= 3'd4));

    // R11: captured address is held while a lookup is in flight
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.orig));

    // R10: the divider is only waited on while it is running or finishing
    p_wait_div_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT) |-> (div_busy || div_done));

endmodule

// File: tb/chan_ilv_remover_tb_top.sv
module chan_ilv_remover_tb_top;

    localparam int CLK_P  = 10;
    localparam int NE     = 8;
    localparam int NC     = 3;
    localparam int AW     = 46;
    localparam int DIV_C  = AW + 2;
    localparam longint unsigned M46 = (64'd1 << AW) - 64'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = '0;
    logic [2:0]    cfg_ent = '0;
    logic [1:0]    cfg_ch = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          start = 1'b0;
    logic [AW-1:0] sys_addr = '0;
    logic [1:0]    chan_sel = '0;
    logic          done, no_entry;
    logic [AW-1:0] chan_addr;
    logic [3:0]    skt_ways;
    logic [2:0]    chn_ways;

    chan_ilv_remover dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_ent(cfg_ent), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
        .start(start), .sys_addr(sys_addr), .chan_sel(chan_sel),
        .done(done), .no_entry(no_entry), .chan_addr(chan_addr),
        .skt_ways(skt_ways), .chn_ways(chn_ways)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    longint unsigned base_m [NE];
    longint unsigned way_m  [NE];
    longint unsigned off_m  [NC][NE];

    task automatic chk(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int kind, input int ent, input int ch,
                             input longint unsigned data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_ent = 3'(ent);
        cfg_ch = 2'(ch); cfg_wdata = data[31:0];
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        // R12 word selection mirrored in the model
        case (kind)
            0: base_m[ent] = data;
            1: way_m[ent] = data;
            2: off_m[ch][ent] = data;
            default: ;
        endcase
    endtask

    task automatic set_entry(input int e, input int lo, input int hi, input int sg,
                             input int cg, input int swc, input int cwc);
        cfg_write(0, e, 0, (longint'(lo) << 12) | (longint'(cg) << 6) | (longint'(sg) << 4));
        cfg_write(1, e, 0, (longint'(hi) << 12) | (longint'(swc) << 10) | (longint'(cwc) << 8));
        for (int c = 0; c < NC; c++)
            cfg_write(2, e, c, longint'(e * 4 + c) << 4);
    endtask

    function automatic int gran(input longint unsigned code);
        case (code)
            0: return 6;
            1: return 8;
            2: return 12;
            default: return 30;
        endcase
    endfunction

    function automatic longint unsigned rmv(input longint unsigned v, input int s,
                                            input int w, input longint unsigned low);
        return ((((v >> s) / w) << s) | (low & ((64'd1 << s) - 64'd1))) & M46;
    endfunction

    task automatic model(input longint unsigned a, input int ch, output bit hit,
                         output longint unsigned ca, output int sw, output int cw,
                         output int lat);
        int e = -1;
        for (int i = NE - 1; i >= 0; i--) begin
            longint unsigned lo = ((base_m[i] >> 12) & 64'hFFFFF) << 26;
            longint unsigned hi = (((way_m[i] >> 12) & 64'hFFFFF) << 26) | 64'h3FFFFFF;
            if (lo <= a && a <= hi) e = i;
        end
        hit = (e >= 0);
        ca = 0; sw = 0; cw = 0; lat = 2;
        if (hit) begin
            int sg = gran((base_m[e] >> 4) & 3);
            int cg = gran((base_m[e] >> 6) & 3);
            sw = 1 << ((way_m[e] >> 10) & 3);
            cw = int'((way_m[e] >> 8) & 3) + 1;
            ca = (a - (((off_m[ch][e] >> 4) & 64'hFFFFF) << 26)) & M46;
            if (cw == 3 && sg > cg) begin
                ca = rmv(ca, cg, cw, ca);
                ca = rmv(ca, sg, sw, ca);
                lat = 2 + DIV_C + 1;
            end else begin
                ca = rmv(ca, sg, sw, a);
                ca = rmv(ca, cg, cw, a);
                lat = 2 + 1 + ((cw == 3) ? DIV_C : 1);
            end
        end
    endtask

    task automatic run(input longint unsigned a, input int ch, input string tag,
                       input bit intrude);
        bit hit; longint unsigned ca; int sw, cw, lat;
        model(a, ch, hit, ca, sw, cw, lat);
        @(negedge clk);
        start = 1'b1; sys_addr = a[AW-1:0]; chan_sel = 2'(ch);
        for (int n = 1; n <= lat; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 1) start = 1'b0;
            if (intrude && n == 3) begin
                start = 1'b1; sys_addr = a[AW-1:0] ^ 46'h3_0000_0000; chan_sel = 2'((ch + 1) % NC);
            end
            if (intrude && n == 4) start = 1'b0;
            chk(done == (n == lat), {tag, " R10 done timing"}, 64'(done), 64'(n == lat));
        end
        chk(no_entry == !hit, {tag, " R4 no_entry"}, 64'(no_entry), 64'(!hit));
        if (hit) begin
            chk(64'(chan_addr) == ca, {tag, " R8 chan_addr"}, 64'(chan_addr), ca);
            chk(int'(skt_ways) == sw, {tag, " R5 skt_ways"}, 64'(skt_ways), 64'(sw));
            chk(int'(chn_ways) == cw, {tag, " R5 chn_ways"}, 64'(chn_ways), 64'(cw));
        end
        @(posedge clk);
        @(negedge clk);
        chk(!done, {tag, " R10 single pulse"}, 64'(done), 64'd0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) begin
            base_m[i] = 0; way_m[i] = 0;
            for (int c = 0; c < NC; c++) off_m[c][i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!done && !no_entry, "R1 flags after reset", 64'({done, no_entry}), 0);
        chk(chan_addr == '0 && skt_ways == '0 && chn_ways == '0, "R1 outputs after reset",
            64'(chan_addr), 0);

        set_entry(0, 20'h000, 20'h0FF, 0, 1, 1, 1);
        set_entry(1, 20'h100, 20'h1FF, 2, 0, 1, 2);
        set_entry(2, 20'h200, 20'h2FF, 0, 1, 0, 2);
        set_entry(3, 20'h300, 20'h3FF, 3, 2, 3, 3);
        set_entry(4, 20'h300, 20'h4FF, 1, 1, 2, 2);
        for (int e = 5; e < NE; e++) set_entry(e, 20'hFFFFF, 20'h00000, 0, 0, 0, 0);

        run((64'h080 << 26) | 64'h12345, 0, "R8 R7 socket-first pow2", 0);
        run((64'h100 << 26) - 1, 1, "R2 limit edge", 0);
        run(64'h100 << 26, 2, "R2 base edge", 0);
        run((64'h1A5 << 26) | 64'h2ABCDEF, 1, "R9 channel-first div3", 0);
        run((64'h2F0 << 26) | 64'h1357, 0, "R6 R8 socket-first div3", 0);
        run((64'h3C0 << 26) | 64'h3FFFABC, 2, "R3 R7 overlap priority bit30", 0);
        run((64'h480 << 26) | 64'h0ACE, 1, "R3 R9 fallthrough equal bits", 0);
        run(64'h600 << 26, 0, "R4 no entry", 0);
        run((64'h1A5 << 26) | 64'h1234567, 0, "R11 start while busy", 1);
        cfg_write(3, 0, 0, 64'hFFFFF000);
        run((64'h080 << 26) | 64'h12345, 0, "R12 kind3 ignored", 0);
        set_entry(5, 20'h500, 20'h6FF, 0, 0, 0, 0);
        run(64'h600 << 26, 0, "R12 R6 reprogrammed entry", 0);

        report();
        $finish;
    end

endmodule